// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block issues a single SD/MMC command on the bidirectional CMD line and, when asked, collects the card's reply. Software loads a 32-bit argument and then a command word. The command word carries a 6-bit command index, a 2-bit reply mode, a go bit, and two tags. The engine builds the 48-bit command frame with its CRC7 and shifts it out one bit per card-clock enable pulse. It then releases the line and waits a bounded time for the reply start bit. It captures a 48-bit or 136-bit reply and records the outcome in sticky status flags, which are cleared by writing ones. The tags mark a stop-transmission command and a command that opens a data transfer. The engine does not act on them; it presents them to a separate data path.

The command word keeps its go bit after the command finishes. Once the go bit is set, the only accepted write to the command word is all-zero. That write clears the word and abandons any command in flight, so the next command can be started.

Top module: `sdcmd_engine`

## Requirements
- R1: The frame is shifted out MSB first, one bit per `card_clk_en` pulse, as start 0, direction 1, 6-bit index, 32-bit argument, CRC7 (x^7+x^3+1 over the first 40 bits), end 1. `cmd_oe` is high for exactly those 48 bits. `cmd_out` idles at 1.
- R2: Command word layout (address 1): index [5:0], reply mode [7:6], go [8], stop tag [9], data tag [10]. Writing it with go set while the stored go bit is 0 starts a command. The go bit stays set after completion.
- R3: While the stored go bit is 1, a nonzero write to address 1 is ignored and the frame continues unchanged. A zero write clears the word, releases the line and abandons the command without raising any flag.
- R4: With mode 00 (no reply), status bit 0 (sent) is raised on the pulse that ends the 48th bit, and the engine goes idle.
- R5: With mode 01 (short, checked), a 48-bit reply whose CRC7 over its first 40 bits matches raises status bit 1 (reply end). A mismatch raises status bit 2 (CRC fail) instead.
- R6: With mode 10 (short, unchecked), a received 48-bit reply always raises status bit 1, whatever its CRC field holds.
- R7: With mode 11 (long), a 136-bit reply raises status bit 1 with no CRC check. Addresses 5, 6, 7 and 8 receive reply bits [127:96], [95:64], [63:32] and [31:0], most significant word at address 5.
- R8: After a short reply, address 4 holds reply bits [45:40] (the echoed index), address 5 holds bits [39:8], and addresses 6 to 8 read 0.
- R9: After the end bit, a start bit (0) seen within 64 `card_clk_en` pulses is accepted. If 64 pulses in a row sample 1, status bit 3 (timeout) is raised and the engine goes idle.
- R10: Status flags [3:0] at address 2 are sticky. Writing 1s to address 3 clears the matching flags and leaves the others.
- R11: The stop and data tags of the stored command word appear on `cmd_stop_tag` and `cmd_data_tag`.
- R12: Status bit 4 is 1 while a command is active. After reset, every register reads 0, `cmd_oe` is 0 and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_clk_en | input | 1 | One-cycle pulse per card clock bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_stop_tag | output | 1 | Stop tag of the stored command word |
| cmd_data_tag | output | 1 | Data tag of the stored command word |

## Verification
The hardest situations to reach are the edges of the reply window and a rewrite that lands mid-frame. The bench plays the card itself, counting enable pulses after the end bit. It holds the line high for exactly 63 pulses before the start bit in one run and for 64 pulses with no start bit in another, so both sides of the window are checked. For the guard, it stops pulsing part-way through a frame, writes the command word, and then resumes. This proves that a nonzero write leaves the shifted bits intact and that a zero write silences the line with no flag raised.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int REG_W      = 32;
    localparam int IDX_W      = 6;
    localparam int CRC_W      = 7;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CRC_SPAN   = 40;
    localparam int CW_W       = 11;
    localparam int CW_GO      = 8;
    localparam int CW_STOP    = 9;
    localparam int CW_DATA    = 10;
    localparam int NFLAG      = 4;
    localparam int RSP_WORDS  = 4;

    localparam int A_ARG  = 0;
    localparam int A_CMD  = 1;
    localparam int A_STAT = 2;
    localparam int A_CLR  = 3;
    localparam int A_RIDX = 4;
    localparam int A_RSP0 = 5;

    typedef enum logic [1:0] {
        RSP_NONE      = 2'b00,
        RSP_SHORT_CRC = 2'b01,
        RSP_SHORT_RAW = 2'b10,
        RSP_LONG      = 2'b11
    } rsp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX
    } seq_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
    parameter int W = 40
) (
    input  logic [W-1:0] bits_i,
    output logic [6:0]   crc_o
);
    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = W - 1; i >= 0; i--) begin
            fb = bits_i[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        crc_o = c;
    end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 start_i,
    input  logic                 abort_i,
    input  rsp_mode_e            mode_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [REG_W-1:0]     arg_i,
    input  logic                 cmd_in_i,
    output logic                 cmd_out_o,
    output logic                 cmd_oe_o,
    output logic                 busy_o,
    output logic [NFLAG-1:0]     ev_o,
    output logic                 rsp_valid_o,
    output logic [LONG_BITS-1:0] rsp_frame_o
);
    localparam int CNT_W = $clog2(LONG_BITS + 1);
    localparam int TMO_W = $clog2(TMO_TICKS + 1);

    typedef struct packed {
        seq_state_e            state;
        rsp_mode_e             mode;
        logic [SHORT_BITS-1:0] txsh;
        logic [CNT_W-1:0]      cnt;
        logic [TMO_W-1:0]      wcnt;
        logic [LONG_BITS-1:0]  rxsh;
    } seq_t;

    seq_t q, d;
    logic [CRC_W-1:0]     tx_crc, rx_crc;
    logic [LONG_BITS-1:0] rx_next;
    logic [CNT_W-1:0]     rx_len;

    assign rx_next = {q.rxsh[LONG_BITS-2:0], cmd_in_i};
    assign rx_len  = (q.mode == RSP_LONG) ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);

    sdcmd_crc7 #(.W(CRC_SPAN)) u_tx_crc (.bits_i({2'b01, idx_i, arg_i}), .crc_o(tx_crc));
    sdcmd_crc7 #(.W(CRC_SPAN)) u_rx_crc (.bits_i(rx_next[SHORT_BITS-1:8]), .crc_o(rx_crc));

    always_comb begin
        d           = q;
        ev_o        = '0;
        rsp_valid_o = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_TX;
                    d.mode  = mode_i;
                    d.txsh  = {2'b01, idx_i, arg_i, tx_crc, 1'b1};
                    d.cnt   = '0;
                end
            end
            ST_TX: begin
                if (tick_i) begin
                    d.txsh = {q.txsh[SHORT_BITS-2:0], 1'b1};
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(SHORT_BITS - 1)) begin
                        if (q.mode == RSP_NONE) begin
                            ev_o[0] = 1'b1;
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_WAIT;
                            d.wcnt  = '0;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (tick_i) begin
                    if (!cmd_in_i) begin
                        d.state = ST_RX;
                        d.cnt   = CNT_W'(1);
                        d.rxsh  = rx_next;
                    end else if (q.wcnt == TMO_W'(TMO_TICKS - 1)) begin
                        ev_o[3] = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            ST_RX: begin
                if (tick_i) begin
                    d.rxsh = rx_next;
                    d.cnt  = q.cnt + 1'b1;
                    if ((q.cnt + 1'b1) == rx_len) begin
                        rsp_valid_o = 1'b1;
                        d.state     = ST_IDLE;
                        if (q.mode == RSP_SHORT_CRC && rx_crc != rx_next[7:1]) ev_o[2] = 1'b1;
                        else                                                    ev_o[1] = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (abort_i) begin
            d.state     = ST_IDLE;
            ev_o        = '0;
            rsp_valid_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, mode: RSP_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_oe_o    = (q.state == ST_TX);
    assign cmd_out_o   = (q.state == ST_TX) ? q.txsh[SHORT_BITS-1] : 1'b1;
    assign busy_o      = (q.state != ST_IDLE);
    assign rsp_frame_o = rx_next;
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic [NFLAG-1:0]     ev_i,
    input  logic                 rsp_valid_i,
    input  logic [LONG_BITS-1:0] rsp_frame_i,
    input  logic                 busy_i,
    output logic                 start_o,
    output logic                 abort_o,
    output rsp_mode_e            mode_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [REG_W-1:0]     arg_o,
    output logic [NFLAG-1:0]     flags_o,
    output logic                 stop_tag_o,
    output logic                 data_tag_o
);
    typedef struct packed {
        logic [REG_W-1:0]                  arg;
        logic [CW_W-1:0]                   cmdw;
        logic [NFLAG-1:0]                  flags;
        logic [IDX_W-1:0]                  ridx;
        logic [RSP_WORDS-1:0][REG_W-1:0]   rw;
        logic                              start;
        logic                              abort;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        if (wr_en_i) begin
            case (int'(wr_addr_i))
                A_ARG: d.arg = wr_data_i;
                A_CMD: begin
                    if (q.cmdw[CW_GO]) begin
                        if (wr_data_i == '0) begin
                            d.cmdw  = '0;
                            d.abort = 1'b1;
                        end
                    end else begin
                        d.cmdw  = wr_data_i[CW_W-1:0];
                        d.start = wr_data_i[CW_GO];
                    end
                end
                A_CLR:   d.flags = q.flags & ~wr_data_i[NFLAG-1:0];
                default: ;
            endcase
        end
        d.flags = d.flags | ev_i;
        if (rsp_valid_i) begin
            if (mode_o == RSP_LONG) begin
                d.ridx = rsp_frame_i[133:128];
                for (int k = 0; k < RSP_WORDS; k++) begin
                    d.rw[k] = rsp_frame_i[127 - 32*k -: 32];
                end
            end else begin
                d.ridx  = rsp_frame_i[45:40];
                d.rw    = '0;
                d.rw[0] = rsp_frame_i[39:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        case (int'(rd_addr_i))
            A_ARG:   rd_data_o = q.arg;
            A_CMD:   rd_data_o = REG_W'(q.cmdw);
            A_STAT:  rd_data_o = REG_W'({busy_i, q.flags});
            A_RIDX:  rd_data_o = REG_W'(q.ridx);
            default: begin
                for (int k = 0; k < RSP_WORDS; k++) begin
                    if (int'(rd_addr_i) == A_RSP0 + k) rd_data_o = q.rw[k];
                end
            end
        endcase
    end

    assign start_o    = q.start;
    assign abort_o    = q.abort;
    assign mode_o     = rsp_mode_e'(q.cmdw[7:6]);
    assign idx_o      = q.cmdw[IDX_W-1:0];
    assign arg_o      = q.arg;
    assign flags_o    = q.flags;
    assign stop_tag_o = q.cmdw[CW_STOP];
    assign data_tag_o = q.cmdw[CW_DATA];
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int TMO_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_clk_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              cmd_stop_tag,
    output logic              cmd_data_tag
);
    logic                 start_p, abort_p, busy, rsp_valid;
    logic [NFLAG-1:0]     ev, flags;
    logic [LONG_BITS-1:0] rsp_frame;
    rsp_mode_e            mode;
    logic [IDX_W-1:0]     idx;
    logic [REG_W-1:0]     arg;

    sdcmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(reg_wr), .wr_addr_i(reg_waddr), .wr_data_i(reg_wdata),
        .rd_addr_i(reg_raddr), .rd_data_o(reg_rdata),
        .ev_i(ev), .rsp_valid_i(rsp_valid), .rsp_frame_i(rsp_frame), .busy_i(busy),
        .start_o(start_p), .abort_o(abort_p), .mode_o(mode), .idx_o(idx), .arg_o(arg),
        .flags_o(flags), .stop_tag_o(cmd_stop_tag), .data_tag_o(cmd_data_tag)
    );

    sdcmd_seq #(.TMO_TICKS(TMO_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(card_clk_en),
        .start_i(start_p), .abort_i(abort_p), .mode_i(mode), .idx_i(idx), .arg_i(arg),
        .cmd_in_i(cmd_in), .cmd_out_o(cmd_out), .cmd_oe_o(cmd_oe), .busy_o(busy),
        .ev_o(ev), .rsp_valid_o(rsp_valid), .rsp_frame_o(rsp_frame)
    );
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_oe,
    input logic              cmd_out,
    input logic              abort_p,
    input logic [NFLAG-1:0]  ev,
    input logic [NFLAG-1:0]  flags,
    input rsp_mode_e         mode,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_waddr,
    input logic [31:0]       reg_wdata
);
    logic clr_wr;
    assign clr_wr = reg_wr && (int'(reg_waddr) == A_CLR);

    AST_TX_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out); // R1
    AST_TX_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_oe) && !$past(abort_p)) |-> $past(cmd_out)); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev)); // R5
    AST_SENT_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |-> (mode == RSP_NONE)); // R4
    AST_CRCFAIL_CHECKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ev[2] |-> (mode == RSP_SHORT_CRC)); // R5

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_wr && reg_wdata[i])) |=> flags[i]); // R10
        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && reg_wdata[i] && !ev[i]) |=> !flags[i]); // R10
    end
endmodule

bind sdcmd_engine sdcmd_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
    .abort_p(abort_p), .ev(ev), .flags(flags), .mode(mode),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
);

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_clk_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, stop_tag, data_tag;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdcmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_stop_tag(stop_tag), .cmd_data_tag(data_tag)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [39:0] v);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic t = v[i] ^ r[6];
            r = {r[5:0], 1'b0} ^ (t ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, crc7({2'b01, idx, arg}), 1'b1};
    endfunction

    function automatic logic [47:0] rsp_frame(input logic [5:0] idx, input logic [31:0] pl, input logic bad);
        logic [6:0] c = crc7({2'b00, idx, pl}) ^ {6'd0, bad};
        return {2'b00, idx, pl, c, 1'b1};
    endfunction

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_raddr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic tick(input logic b);
        @(negedge clk);
        cmd_in = b; card_clk_en = 1'b1;
        @(negedge clk);
        card_clk_en = 1'b0; cmd_in = 1'b1;
    endtask

    task automatic cap(input int n, inout logic [47:0] fr, inout logic alloe);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fr = {fr[46:0], cmd_out};
            alloe = alloe & cmd_oe;
            card_clk_en = 1'b1;
            @(negedge clk);
            card_clk_en = 1'b0;
        end
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] mode, input logic [1:0] tags);
        wr(0, arg);
        wr(1, {21'd0, tags, 1'b1, mode, idx});
    endtask

    task automatic tidy();
        wr(1, 32'd0);
        wr(3, 32'hF);
    endtask

    task automatic send_resp(input int gap, input logic [135:0] fr, input int len);
        repeat (gap) tick(1'b1);
        for (int i = len - 1; i >= 0; i--) tick(fr[i]);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R12", "cmd_oe after reset", 64'(cmd_oe), 64'd0);
        chk("R12", "cmd_out after reset", 64'(cmd_out), 64'd1);
        for (int a = 0; a < 9; a++) begin
            rd(a, v);
            chk("R12", $sformatf("reg %0d after reset", a), 64'(v), 64'd0);
        end
    endtask

    task automatic t_noresp();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd0, 32'd0, 2'b00, 2'b00);
        cap(48, fr, oe);
        chk("R1", "idle-command frame", 64'(fr), 64'h4000_0000_0095);
        chk("R1", "oe over frame", 64'(oe), 64'd1);
        chk("R1", "oe released", 64'(cmd_oe), 64'd0);
        rd(2, v); chk("R4", "status after send", 64'(v), 64'h1);
        rd(1, v); chk("R2", "go bit kept", 64'(v), 64'h100);
        tidy();
    endtask

    task automatic t_short(input logic [1:0] mode, input logic bad, input logic [31:0] exp_stat, input string req);
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd17, 32'h1234_5678, mode, 2'b00);
        cap(48, fr, oe);
        chk("R1", "short-command frame", 64'(fr), 64'(cmd_frame(6'd17, 32'h1234_5678)));
        rd(2, v); chk("R12", "busy while waiting", 64'(v), 64'h10);
        chk("R1", "line released for reply", 64'(cmd_oe), 64'd0);
        send_resp(5, 136'(rsp_frame(6'd17, 32'h0000_0900, bad)), 48);
        rd(2, v); chk(req, "status after short reply", 64'(v), 64'(exp_stat));
        rd(4, v); chk("R8", "reply index", 64'(v), 64'd17);
        rd(5, v); chk("R8", "reply word", 64'(v), 64'h900);
        rd(6, v); chk("R8", "unused word", 64'(v), 64'd0);
        tidy();
    endtask

    task automatic t_long();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        logic [127:0] pl = {32'hA1B2_C3D4, 32'h1122_3344, 32'h5566_7788, 32'h99AA_BBC1};
        issue(6'd2, 32'd0, 2'b11, 2'b00);
        cap(48, fr, oe);
        send_resp(3, {2'b00, 6'h3F, pl}, 136);
        rd(2, v); chk("R7", "status after long reply", 64'(v), 64'h2);
        for (int k = 0; k < 4; k++) begin
            rd(5 + k, v);
            chk("R7", $sformatf("long word %0d", k), 64'(v), 64'(pl[127 - 32*k -: 32]));
        end
        tidy();
    endtask

    task automatic t_timeout();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd8, 32'h1AA, 2'b01, 2'b00);
        cap(48, fr, oe);
        repeat (63) tick(1'b1);
        rd(2, v); chk("R9", "no timeout after 63", 64'(v), 64'h10);
        tick(1'b1);
        rd(2, v); chk("R9", "timeout after 64", 64'(v), 64'h8);
        tidy();
    endtask

    task automatic t_late_start();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd8, 32'h1AA, 2'b01, 2'b00);
        cap(48, fr, oe);
        send_resp(63, 136'(rsp_frame(6'd8, 32'h1AA, 1'b0)), 48);
        rd(2, v); chk("R9", "reply after 63 idle", 64'(v), 64'h2);
        tidy();
    endtask

    task automatic t_w1c();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd0, 32'd0, 2'b00, 2'b00);
        cap(48, fr, oe);
        wr(1, 32'd0);
        wr(3, 32'h2);
        rd(2, v); chk("R10", "other clear keeps flag", 64'(v), 64'h1);
        wr(3, 32'h1);
        rd(2, v); chk("R10", "matching clear", 64'(v), 64'h0);
        tidy();
    endtask

    task automatic t_rewrite();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd5, 32'hCAFE_0001, 2'b00, 2'b00);
        cap(10, fr, oe);
        wr(1, 32'h0000_0127);
        rd(1, v); chk("R3", "nonzero rewrite ignored", 64'(v), 64'h105);
        cap(38, fr, oe);
        chk("R3", "frame intact", 64'(fr), 64'(cmd_frame(6'd5, 32'hCAFE_0001)));
        chk("R3", "oe intact", 64'(oe), 64'd1);
        tidy();
    endtask

    task automatic t_abort();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd9, 32'h0001_0000, 2'b01, 2'b00);
        cap(5, fr, oe);
        wr(1, 32'd0);
        @(negedge clk);
        chk("R3", "oe after abort", 64'(cmd_oe), 64'd0);
        chk("R3", "line idle after abort", 64'(cmd_out), 64'd1);
        rd(1, v); chk("R3", "word cleared", 64'(v), 64'd0);
        repeat (70) tick(1'b1);
        rd(2, v); chk("R3", "no flag after abort", 64'(v), 64'd0);
        tidy();
    endtask

    task automatic t_tags();
        logic [47:0] fr = '0; logic oe = 1'b1; logic [31:0] v;
        issue(6'd12, 32'd0, 2'b00, 2'b11);
        chk("R11", "stop tag", 64'(stop_tag), 64'd1);
        chk("R11", "data tag", 64'(data_tag), 64'd1);
        rd(1, v); chk("R11", "tag readback", 64'(v), 64'h70C);
        cap(48, fr, oe);
        tidy();
        chk("R11", "tags cleared", 64'({stop_tag, data_tag}), 64'd0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_noresp();
        t_short(2'b01, 1'b0, 32'h2, "R5");
        t_short(2'b01, 1'b1, 32'h4, "R5");
        t_short(2'b10, 1'b1, 32'h2, "R6");
        t_long();
        t_timeout();
        t_late_start();
        t_w1c();
        t_rewrite();
        t_abort();
        t_tags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule